// File: doc/BRIEF.md
# Write-Back Direct-Mapped Data Cache Controller

This block is a direct-mapped data cache placed between a processor load/store port and a slower next-level memory. A processor request carries a byte address, a write flag, four byte enables and write data. The controller splits the address into a tag, a line index and an offset within the line. It reads the indexed line's tag, valid bit, dirty bit and data word together, and compares the tag in the cycle after it accepts the request. A hit answers without touching memory. A miss stalls the requester while the line is fetched.

Stores follow a write-back, write-allocate policy. A store hit changes only the cached word and marks the line dirty. A store miss first brings the whole line in and then merges the store bytes into it. Before any line is replaced, a valid dirty victim is copied back to memory word by word. Memory traffic uses one 32-bit word per beat. Each beat holds its request until the memory acknowledges it. Line count and words per line are parameters, and the defaults are small (16 lines of 4 words).

Top module: `wb_dm_cache`

## Requirements
- R1: The byte address is decoded from the least significant end upward: bits [1:0] select a byte, the next log2(LINE_WORDS) bits select a word, the next log2(NUM_LINES) bits select the line, and the remaining upper bits form the tag. Every line transfer uses the addresses line_base + 4*k, with k rising from 0 to LINE_WORDS-1.
- R2: In the first cycle after a synchronous active-high reset, cpu_ready is 1 and both cpu_rvalid and mem_req are 0. Every line is invalid, so the first access to any line misses and performs no write-back.
- R3: A load hit makes no memory request. It raises cpu_rvalid for exactly one cycle, in the second cycle after the accepting cycle, and presents the cached word on cpu_rdata.
- R4: A load miss performs LINE_WORDS read beats (mem_we=0) for the missed line. The response, carrying the requested word, comes in the cycle after the last acknowledge.
- R5: A store hit makes no memory request. Byte enable bit b selects whether data bits [8b+7:8b] are replaced. The response carries the merged word, the line becomes dirty, and later loads return the merged word.
- R6: A store miss first refills the whole line from memory. It then merges the store bytes into the requested word, responds with the merged word and leaves the line dirty.
- R7: When the victim line is valid and dirty, all its words are written (mem_we=1) to the victim's own line addresses, in rising order, before any read beat of the refill.
- R8: cpu_ready drops in the cycle after a request is accepted and stays low through the response cycle. cpu_rvalid lasts one cycle, and cpu_ready is 1 again in the following cycle.
- R9: mem_req stays high with stable mem_addr, mem_we and write data until an acknowledge is sampled. Each acknowledge completes one beat, and every memory address is word aligned.
- R10: A valid but clean victim is replaced with no write beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_ready | output | 1 | Controller can accept a request |
| cpu_addr | input | ADDR_W | Byte address of the access |
| cpu_we | input | 1 | 1 for a store, 0 for a load |
| cpu_be | input | 4 | Store byte enables |
| cpu_wdata | input | 32 | Store data |
| cpu_rvalid | output | 1 | One-cycle response strobe |
| cpu_rdata | output | 32 | Word after the access (loaded or merged) |
| mem_req | output | 1 | Memory beat requested |
| mem_we | output | 1 | 1 for a write-back beat, 0 for a refill beat |
| mem_addr | output | ADDR_W | Word-aligned beat address |
| mem_wdata | output | 32 | Write-back data |
| mem_ack | input | 1 | Memory completes the current beat |
| mem_rdata | input | 32 | Refill data, valid with mem_ack |

## Verification
The assertions watch, on every cycle, the handshake rules: the stall after acceptance, the one-cycle response, the beat hold until acknowledge with aligned addresses, and the rule that no write beat follows a read beat within one miss. Data correctness needs the bench's cycle-by-cycle reference model. The scenarios that show it are byte-enable merges seen by later loads, dirty eviction followed by a reload that must return the written-back bytes, clean eviction with no write traffic, and a long pseudo-random mix of conflicting lines.

// File: rtl/cache_pkg.sv
package cache_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_WRITEBACK,
    ST_REFILL,
    ST_RESPOND
  } cache_state_e;

  // Byte-lane merge: lane b of new_w replaces lane b of old_w when be[b] is set.
  function automatic logic [31:0] merge_bytes(input logic [31:0] old_w,
                                              input logic [31:0] new_w,
                                              input logic [3:0]  be);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) begin
      r[8*b +: 8] = be[b] ? new_w[8*b +: 8] : old_w[8*b +: 8];
    end
    return r;
  endfunction

endpackage

// File: rtl/cache_addr_split.sv
module cache_addr_split #(
  parameter int ADDR_W = 32,
  parameter int WSEL_W = 2,
  parameter int IDX_W  = 4,
  localparam int OFF_W = WSEL_W + 2,
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [TAG_W-1:0]  tag,
  output logic [IDX_W-1:0]  idx,
  output logic [WSEL_W-1:0] wsel
);
  logic [1:0] unused_byte_sel;

  assign unused_byte_sel = addr[1:0];
  assign wsel = addr[2 +: WSEL_W];
  assign idx  = addr[OFF_W +: IDX_W];
  assign tag  = addr[ADDR_W-1 -: TAG_W];
endmodule

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
  parameter int NUM_LINES = 16,
  parameter int TAG_W     = 24,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag,
  output logic             rd_valid,
  output logic             rd_dirty,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             wr_dirty
);
  logic [TAG_W-1:0]     tag_mem [NUM_LINES];
  logic [NUM_LINES-1:0] valid_q;
  logic [NUM_LINES-1:0] dirty_q;

  // Tag array: no reset, so it can map onto block RAM.
  always_ff @(posedge clk) begin
    if (wr_en) tag_mem[wr_idx] <= wr_tag;
    if (rd_en) rd_tag <= tag_mem[rd_idx];
  end

  // State bits: cleared by reset.
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= '0;
      dirty_q  <= '0;
      rd_valid <= 1'b0;
      rd_dirty <= 1'b0;
    end else begin
      if (wr_en) begin
        valid_q[wr_idx] <= 1'b1;
        dirty_q[wr_idx] <= wr_dirty;
      end
      if (rd_en) begin
        rd_valid <= valid_q[rd_idx];
        rd_dirty <= dirty_q[rd_idx];
      end
    end
  end
endmodule

// File: rtl/cache_data_store.sv
module cache_data_store #(
  parameter int DEPTH   = 64,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic [AW-1:0] rd_addr,
  output logic [31:0]   rd_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [31:0]   wr_data
);
  logic [31:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/wb_dm_cache.sv
module wb_dm_cache
  import cache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int NUM_LINES  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_valid,
  output logic              cpu_ready,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_we,
  input  logic [3:0]        cpu_be,
  input  logic [31:0]       cpu_wdata,
  output logic              cpu_rvalid,
  output logic [31:0]       cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata
);
  localparam int WSEL_W = $clog2(LINE_WORDS);
  localparam int IDX_W  = $clog2(NUM_LINES);
  localparam int OFF_W  = WSEL_W + 2;
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int DEPTH  = NUM_LINES * LINE_WORDS;
  localparam int DA_W   = IDX_W + WSEL_W;
  localparam logic [WSEL_W-1:0] LAST_BEAT = WSEL_W'(LINE_WORDS - 1);

  cache_state_e state_q;

  // Latched request
  logic [TAG_W-1:0]  req_tag;
  logic [IDX_W-1:0]  req_idx;
  logic [WSEL_W-1:0] req_wsel;
  logic              req_we;
  logic [3:0]        req_be;
  logic [31:0]       req_wdata;
  logic [WSEL_W-1:0] beat_q;
  logic [31:0]       resp_q;

  // Incoming address fields
  logic [TAG_W-1:0]  in_tag;
  logic [IDX_W-1:0]  in_idx;
  logic [WSEL_W-1:0] in_wsel;

  cache_addr_split #(
    .ADDR_W (ADDR_W),
    .WSEL_W (WSEL_W),
    .IDX_W  (IDX_W)
  ) u_split (
    .addr (cpu_addr),
    .tag  (in_tag),
    .idx  (in_idx),
    .wsel (in_wsel)
  );

  // Tag store
  logic             ts_rd_en;
  logic [TAG_W-1:0] ts_tag;
  logic             ts_valid;
  logic             ts_dirty;
  logic             ts_wr_en;
  logic             ts_wr_dirty;

  cache_tag_store #(
    .NUM_LINES (NUM_LINES),
    .TAG_W     (TAG_W)
  ) u_tags (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (ts_rd_en),
    .rd_idx   (in_idx),
    .rd_tag   (ts_tag),
    .rd_valid (ts_valid),
    .rd_dirty (ts_dirty),
    .wr_en    (ts_wr_en),
    .wr_idx   (req_idx),
    .wr_tag   (req_tag),
    .wr_dirty (ts_wr_dirty)
  );

  // Data store
  logic [DA_W-1:0] ds_rd_addr;
  logic [31:0]     ds_rd_word;
  logic            ds_wr_en;
  logic [DA_W-1:0] ds_wr_addr;
  logic [31:0]     ds_wr_data;

  cache_data_store #(
    .DEPTH (DEPTH)
  ) u_data (
    .clk     (clk),
    .rd_addr (ds_rd_addr),
    .rd_data (ds_rd_word),
    .wr_en   (ds_wr_en),
    .wr_addr (ds_wr_addr),
    .wr_data (ds_wr_data)
  );

  // Lookup and beat decode
  logic        hit;
  logic        in_lookup;
  logic        in_wb;
  logic        in_refill;
  logic        last_beat;
  logic        accept;
  logic [31:0] hit_merged;
  logic [31:0] fill_word;

  assign in_lookup  = (state_q == ST_LOOKUP);
  assign in_wb      = (state_q == ST_WRITEBACK);
  assign in_refill  = (state_q == ST_REFILL);
  assign accept     = (state_q == ST_IDLE) && cpu_valid;
  assign hit        = ts_valid && (ts_tag == req_tag);
  assign last_beat  = (beat_q == LAST_BEAT);
  assign hit_merged = merge_bytes(ds_rd_word, req_wdata, req_be);
  assign fill_word  = (req_we && (beat_q == req_wsel))
                      ? merge_bytes(mem_rdata, req_wdata, req_be) : mem_rdata;

  assign ts_rd_en    = (state_q == ST_IDLE);
  assign ts_wr_en    = (in_lookup && hit && req_we) || (in_refill && mem_ack && last_beat);
  assign ts_wr_dirty = req_we;

  // Read address: the write-back path looks one beat ahead, so the
  // next word is already registered when the current beat is acknowledged.
  always_comb begin
    unique case (state_q)
      ST_IDLE:      ds_rd_addr = {in_idx, in_wsel};
      ST_LOOKUP:    ds_rd_addr = {req_idx, {WSEL_W{1'b0}}};
      ST_WRITEBACK: ds_rd_addr = {req_idx, mem_ack ? beat_q + WSEL_W'(1) : beat_q};
      default:      ds_rd_addr = {req_idx, req_wsel};
    endcase
  end

  always_comb begin
    ds_wr_en   = 1'b0;
    ds_wr_addr = {req_idx, req_wsel};
    ds_wr_data = hit_merged;
    if (in_lookup && hit && req_we) begin
      ds_wr_en = 1'b1;
    end else if (in_refill && mem_ack) begin
      ds_wr_en   = 1'b1;
      ds_wr_addr = {req_idx, beat_q};
      ds_wr_data = fill_word;
    end
  end

  // Control FSM
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept) state_q <= ST_LOOKUP;
        end
        ST_LOOKUP: begin
          beat_q <= '0;
          if (hit)                       state_q <= ST_RESPOND;
          else if (ts_valid && ts_dirty) state_q <= ST_WRITEBACK;
          else                           state_q <= ST_REFILL;
        end
        ST_WRITEBACK: begin
          if (mem_ack) begin
            beat_q <= beat_q + WSEL_W'(1);
            if (last_beat) state_q <= ST_REFILL;
          end
        end
        ST_REFILL: begin
          if (mem_ack) begin
            beat_q <= beat_q + WSEL_W'(1);
            if (last_beat) state_q <= ST_RESPOND;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Request capture and response word
  always_ff @(posedge clk) begin
    if (accept) begin
      req_tag   <= in_tag;
      req_idx   <= in_idx;
      req_wsel  <= in_wsel;
      req_we    <= cpu_we;
      req_be    <= cpu_be;
      req_wdata <= cpu_wdata;
    end
    if (in_lookup && hit) begin
      resp_q <= req_we ? hit_merged : ds_rd_word;
    end else if (in_refill && mem_ack && (beat_q == req_wsel)) begin
      resp_q <= fill_word;
    end
  end

  // Ports
  assign cpu_ready  = (state_q == ST_IDLE);
  assign cpu_rvalid = (state_q == ST_RESPOND);
  assign cpu_rdata  = resp_q;
  assign mem_req    = in_wb || in_refill;
  assign mem_we     = in_wb;
  assign mem_addr   = {(in_wb ? ts_tag : req_tag), req_idx, beat_q, 2'b00};
  assign mem_wdata  = ds_rd_word;

endmodule

// File: rtl/cache_checker.sv
module cache_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_valid,
  input logic              cpu_ready,
  input logic              cpu_rvalid,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       mem_wdata
);

  AST_STALL_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (cpu_valid && cpu_ready) |=> !cpu_ready); // R8

  AST_RESP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    cpu_rvalid |=> (!cpu_rvalid && cpu_ready)); // R8

  AST_NO_READY_IN_MISS: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (!cpu_ready && !cpu_rvalid)); // R8

  AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R9

  AST_BEAT_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[1:0] == 2'b00)); // R9

  AST_WB_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && !mem_ack) |=> $stable(mem_wdata)); // R7

  AST_WB_BEFORE_FILL: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we) |=> !mem_we); // R7

endmodule

bind wb_dm_cache cache_checker #(.ADDR_W(ADDR_W)) u_checker (
  .clk        (clk),
  .rst        (rst),
  .cpu_valid  (cpu_valid),
  .cpu_ready  (cpu_ready),
  .cpu_rvalid (cpu_rvalid),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_ack    (mem_ack),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata)
);

// File: tb/tb_wb_dm_cache.sv
module tb_wb_dm_cache;
  localparam int LW  = 4;
  localparam int NL  = 16;
  localparam int LAT = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_valid = 1'b0;
  logic        cpu_ready;
  logic [31:0] cpu_addr = '0;
  logic        cpu_we = 1'b0;
  logic [3:0]  cpu_be = '0;
  logic [31:0] cpu_wdata = '0;
  logic        cpu_rvalid;
  logic [31:0] cpu_rdata;
  logic        mem_req;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  wb_dm_cache #(.ADDR_W(32), .LINE_WORDS(LW), .NUM_LINES(NL)) dut (
    .clk(clk), .rst(rst),
    .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_addr(cpu_addr),
    .cpu_we(cpu_we), .cpu_be(cpu_be), .cpu_wdata(cpu_wdata),
    .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  // Behavioural model state
  logic [31:0] mem_model [logic [31:0]];
  logic [31:0] ref_data [NL*LW];
  int          ref_tag  [NL];
  bit          ref_v    [NL];
  bit          ref_d    [NL];

  function automatic logic [31:0] mem_get(input logic [31:0] a);
    if (mem_model.exists(a)) return mem_model[a];
    return (a * 32'h9E3779B1) ^ 32'h0F0F1234;
  endfunction

  function automatic logic [31:0] lane_merge(input logic [31:0] o, input logic [31:0] n,
                                             input logic [3:0] be);
    logic [31:0] r = o;
    for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = n[8*b +: 8];
    return r;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic [31:0] a, input logic w, input logic [3:0] be,
                        input logic [31:0] d);
    int idx  = int'((a >> 4) % NL);
    int tg   = int'(a >> 8);
    int ws   = int'((a >> 2) % LW);
    bit hit  = ref_v[idx] && (ref_tag[idx] == tg);
    logic [31:0] q_addr [$];
    bit          q_we   [$];
    logic [31:0] q_wd   [$];
    string lab_fill;
    string lab_resp;
    logic [31:0] exp_resp;

    lab_fill = !ref_v[idx] ? "R2" : (ref_d[idx] ? "R7" : "R10");
    lab_resp = hit ? (w ? "R5" : "R3") : (w ? "R6" : "R4");
    if (!hit) begin
      if (ref_v[idx] && ref_d[idx])
        for (int k = 0; k < LW; k++) begin
          q_addr.push_back(32'((ref_tag[idx] << 8) | (idx << 4) | (k << 2)));
          q_we.push_back(1'b1);
          q_wd.push_back(ref_data[idx*LW + k]);
        end
      for (int k = 0; k < LW; k++) begin
        q_addr.push_back(32'((tg << 8) | (idx << 4) | (k << 2)));
        q_we.push_back(1'b0);
        q_wd.push_back('0);
        ref_data[idx*LW + k] = mem_get(32'((tg << 8) | (idx << 4) | (k << 2)));
      end
      ref_tag[idx] = tg;
      ref_v[idx]   = 1'b1;
      ref_d[idx]   = 1'b0;
    end
    if (w) begin
      ref_data[idx*LW + ws] = lane_merge(ref_data[idx*LW + ws], d, be);
      ref_d[idx] = 1'b1;
    end
    exp_resp = ref_data[idx*LW + ws];

    // Accepting cycle
    chk("R8", "ready before request", 32'(cpu_ready), 1);
    cpu_addr = a; cpu_we = w; cpu_be = be; cpu_wdata = d; cpu_valid = 1'b1;
    @(negedge clk);
    cpu_valid = 1'b0;
    chk("R8", "ready in lookup", 32'(cpu_ready), 0);
    chk(lab_resp, "mem_req in lookup", 32'(mem_req), 0);
    chk("R8", "rvalid in lookup", 32'(cpu_rvalid), 0);

    for (int b = 0; b < q_addr.size(); b++) begin
      for (int c = 0; c <= LAT; c++) begin
        @(negedge clk);
        mem_ack = 1'b0;
        chk("R9", "mem_req held", 32'(mem_req), 1);
        chk("R8", "ready during miss", 32'(cpu_ready), 0);
        chk(b == 0 ? lab_fill : "R7", "mem_we", 32'(mem_we), 32'(q_we[b]));
        chk(q_we[b] ? "R7" : "R1", "mem_addr", mem_addr, q_addr[b]);
        if (q_we[b]) chk("R7", "writeback data", mem_wdata, q_wd[b]);
        if (c == LAT) begin
          if (mem_we) mem_model[mem_addr] = mem_wdata;
          else        mem_rdata = mem_get(mem_addr);
          mem_ack = 1'b1;
        end
      end
    end

    @(negedge clk);
    mem_ack = 1'b0;
    chk("R8", "rvalid", 32'(cpu_rvalid), 1);
    chk(lab_resp, "rdata", cpu_rdata, exp_resp);
    chk("R8", "ready in response", 32'(cpu_ready), 0);
    chk(lab_resp, "mem_req in response", 32'(mem_req), 0);
    @(negedge clk);
    chk("R8", "rvalid single", 32'(cpu_rvalid), 0);
    chk("R8", "ready restored", 32'(cpu_ready), 1);
  endtask

  initial begin
    for (int i = 0; i < NL; i++) begin
      ref_v[i] = 0; ref_d[i] = 0; ref_tag[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R2", "reset ready", 32'(cpu_ready), 1);
    chk("R2", "reset rvalid", 32'(cpu_rvalid), 0);
    chk("R2", "reset mem_req", 32'(mem_req), 0);

    access(32'h0000_0100, 1'b0, 4'h0, 32'h0);          // R2 R4 cold load miss
    access(32'h0000_0104, 1'b0, 4'h0, 32'h0);          // R3 load hit
    access(32'h0000_0108, 1'b1, 4'b0101, 32'hA1B2C3D4); // R5 store hit, lanes 0 and 2
    access(32'h0000_0108, 1'b0, 4'h0, 32'h0);          // R5 merged word read back
    access(32'h0000_0200, 1'b0, 4'h0, 32'h0);          // R7 dirty victim written back
    access(32'h0000_0108, 1'b0, 4'h0, 32'h0);          // R10 clean victim, merged bytes from memory
    access(32'h0000_03F4, 1'b1, 4'b1000, 32'h5500_0000); // R6 store miss allocate
    access(32'h0000_03F4, 1'b1, 4'b1111, 32'h1234_5678); // R5 full-word store hit
    access(32'h0000_07F0, 1'b0, 4'h0, 32'h0);          // R7 evicts dirty line 15

    begin
      logic [31:0] lfsr = 32'hACE1_2468;
      for (int n = 0; n < 300; n++) begin
        logic [31:0] a;
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        a = {22'd0, lfsr[9:8], 2'b00, lfsr[5:4], lfsr[3:2], 2'b00};
        access(a, lfsr[12], lfsr[19:16], lfsr ^ 32'h3C3C_C3C3);
      end
    end

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule